// File: doc/BRIEF.md
# Dual-Operand Compare-and-Swap Sequencer

This block runs an atomic-style double compare-and-swap for a processor core. It takes a select word naming four data registers, two memory addresses and an operand size of either half or full width. On a start pulse it takes a snapshot of the two compare values and the two update values from the register file. It then fetches both memory operands over a request/acknowledge port. Memory is updated only when both fetched operands equal their compare values.

Whether or not the swap happens, the fetched operands are written back into the two compare registers. In half-width mode only the low half of each of those registers is replaced. The block produces condition flags equal to those of a size-matched compare. The pair that decides the flags is the first one that mismatched, or the second pair when the first matched. Bus locking against other masters and address translation faults are handled outside the block.

Top module: `dcas_seq`

## Requirements
- R1: `sel_i` is decoded as follows: bits 11:9 give the first compare register, bits 8:6 the second compare register, bits 5:3 the first update register and bits 2:0 the second update register. `regs_i` holds register k in bits `k*32 +: 32`. All four values are sampled in the cycle where start is accepted.
- R2: The port issues one access at a time. Request, address, write enable and write data stay unchanged until acknowledge. The first address is read, then the second address is read, and only after that can any write occur.
- R3: When both pairs match, the block writes the first update value to the first address and then the second update value to the second address. With `wide_i`=0, `mem_wide_o` is 0, only bits 15:0 of a write are significant, the upper write bits are zero, and only bits 15:0 of read data are used.
- R4: If either pair mismatches, no write request is issued. The whole operation then makes exactly two accesses.
- R5: After the memory phase, the first compare register receives the first loaded value and then the second compare register receives the second loaded value, one per cycle. If both indices are equal, the register ends with the second loaded value.
- R6: With `wide_i`=0, a write-back keeps bits 31:16 of the register as sampled at start and replaces bits 15:0. With `wide_i`=1 it replaces all 32 bits.
- R7: `flags_o` = {N,Z,V,C} of loaded minus compare at the selected size. C is the borrow and V is the signed overflow. The flags come from the first pair when it mismatches and from the second pair otherwise. They hold their value between operations.
- R8: `done_o` pulses for one cycle, in the cycle after the second register write-back, and `busy_o` is low in that cycle. A start pulse while busy is ignored.
- R9: After reset, busy, done, request, register write and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| sel_i | input | 12 | Register select word |
| wide_i | input | 1 | 1 = 32-bit, 0 = 16-bit operands |
| addr_a_i | input | 16 | First memory address |
| addr_b_i | input | 16 | Second memory address |
| regs_i | input | 256 | Flattened read view of eight 32-bit data registers |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_wide_o | output | 1 | Access size, 1 = 32-bit |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes in this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_waddr_o | output | 3 | Write-back register index |
| rf_wdata_o | output | 32 | Write-back data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 4 | {N,Z,V,C} compare flags |

## Verification
A corrupted captured index or snapshot shows up at the ports in the same operation. It appears as a wrong write-back address or merged upper half, or a wrong write value, as soon as done is seen. A wrong state sequence shows up as a write request before the second read acknowledge, a request that changes before acknowledge, or an access count other than two or four. These are caught within the operation that went wrong. A flag selection error shows up at done only when the two pairs disagree, so the sweep covers every combination of match and mismatch at both sizes, with differences chosen to toggle the sign, borrow and overflow.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_A, ST_RD_B, ST_CHK, ST_WR_A, ST_WR_B, ST_WB_A, ST_WB_B
  } seq_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/dcas_cmp.sv
module dcas_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic              wide_i,
  output dcas_pkg::flags_t  flags_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0] diff_full;
  logic [HALF:0]   diff_half;

  assign diff_full = {1'b0, lhs_i} - {1'b0, rhs_i};
  assign diff_half = {1'b0, lhs_i[HALF-1:0]} - {1'b0, rhs_i[HALF-1:0]};

  always_comb begin
    if (wide_i) begin
      flags_o.n = diff_full[DATA_W-1];
      flags_o.z = (diff_full[DATA_W-1:0] == '0);
      flags_o.c = diff_full[DATA_W];
      flags_o.v = (lhs_i[DATA_W-1] != rhs_i[DATA_W-1]) && (diff_full[DATA_W-1] != lhs_i[DATA_W-1]);
    end else begin
      flags_o.n = diff_half[HALF-1];
      flags_o.z = (diff_half[HALF-1:0] == '0);
      flags_o.c = diff_half[HALF];
      flags_o.v = (lhs_i[HALF-1] != rhs_i[HALF-1]) && (diff_half[HALF-1] != lhs_i[HALF-1]);
    end
  end
endmodule

// File: rtl/dcas_merge.sv
module dcas_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] merged_o
);
  localparam int HALF = DATA_W / 2;

  assign merged_o = wide_i ? new_i : {old_i[DATA_W-1:HALF], new_i[HALF-1:0]};
endmodule

// File: rtl/dcas_seq.sv
module dcas_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int SEL_W = 4 * IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic                   wide_i,
  input  logic [ADDR_W-1:0]      addr_a_i,
  input  logic [ADDR_W-1:0]      addr_b_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic                   mem_wide_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   rf_we_o,
  output logic [IDX_W-1:0]       rf_waddr_o,
  output logic [DATA_W-1:0]      rf_wdata_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [3:0]             flags_o
);
  import dcas_pkg::*;

  localparam int HALF = DATA_W / 2;

  seq_state_e        state_q, state_d;
  logic              wide_q, done_q;
  logic [ADDR_W-1:0] addr_q [2];
  logic [IDX_W-1:0]  cidx_q [2];
  logic [DATA_W-1:0] cval_q [2];
  logic [DATA_W-1:0] uval_q [2];
  logic [DATA_W-1:0] ld_q   [2];
  flags_t            flags_q;

  logic [DATA_W-1:0] reg_arr [NREG];
  logic [IDX_W-1:0]  sel_idx [4];
  flags_t            pair_flags [2];
  logic [DATA_W-1:0] wb_data [2];
  logic [DATA_W-1:0] rd_narrow;
  logic              acc_ok, both_eq, use_b;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs_i[g*DATA_W +: DATA_W];
  end

  // field 0 sits in the top bits: first compare, second compare, first update, second update
  for (genvar f = 0; f < 4; f++) begin : g_sel
    assign sel_idx[f] = sel_i[(3-f)*IDX_W +: IDX_W];
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    dcas_cmp #(.DATA_W(DATA_W)) u_cmp (
      .lhs_i  (ld_q[p]),
      .rhs_i  (cval_q[p]),
      .wide_i (wide_q),
      .flags_o(pair_flags[p])
    );
    dcas_merge #(.DATA_W(DATA_W)) u_merge (
      .old_i   (cval_q[p]),
      .new_i   (ld_q[p]),
      .wide_i  (wide_q),
      .merged_o(wb_data[p])
    );
  end

  assign acc_ok    = mem_req_o & mem_ack_i;
  assign both_eq   = pair_flags[0].z & pair_flags[1].z;
  assign rd_narrow = wide_q ? mem_rdata_i : {{(DATA_W-HALF){1'b0}}, mem_rdata_i[HALF-1:0]};
  assign use_b     = (state_q == ST_RD_B) || (state_q == ST_WR_B);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD_A;
      ST_RD_A: if (acc_ok)  state_d = ST_RD_B;
      ST_RD_B: if (acc_ok)  state_d = ST_CHK;
      ST_CHK:  state_d = both_eq ? ST_WR_A : ST_WB_A;
      ST_WR_A: if (acc_ok)  state_d = ST_WR_B;
      ST_WR_B: if (acc_ok)  state_d = ST_WB_A;
      ST_WB_A: state_d = ST_WB_B;
      ST_WB_B: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
      flags_q <= '0;
      for (int p = 0; p < 2; p++) begin
        addr_q[p] <= '0;
        cidx_q[p] <= '0;
        cval_q[p] <= '0;
        uval_q[p] <= '0;
        ld_q[p]   <= '0;
      end
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WB_B);
      if (state_q == ST_IDLE && start_i) begin
        wide_q    <= wide_i;
        addr_q[0] <= addr_a_i;
        addr_q[1] <= addr_b_i;
        for (int p = 0; p < 2; p++) begin
          cidx_q[p] <= sel_idx[p];
          cval_q[p] <= reg_arr[sel_idx[p]];
          uval_q[p] <= reg_arr[sel_idx[2+p]];
        end
      end
      if (state_q == ST_RD_A && acc_ok) ld_q[0] <= rd_narrow;
      if (state_q == ST_RD_B && acc_ok) ld_q[1] <= rd_narrow;
      if (state_q == ST_CHK) flags_q <= pair_flags[0].z ? pair_flags[1] : pair_flags[0];
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                  (state_q == ST_WR_A) || (state_q == ST_WR_B);
    mem_we_o    = (state_q == ST_WR_A) || (state_q == ST_WR_B);
    mem_wide_o  = wide_q;
    mem_addr_o  = use_b ? addr_q[1] : addr_q[0];
    mem_wdata_o = '0;
    if (mem_we_o) begin
      mem_wdata_o = wide_q ? uval_q[use_b] : {{(DATA_W-HALF){1'b0}}, uval_q[use_b][HALF-1:0]};
    end
    rf_we_o    = (state_q == ST_WB_A) || (state_q == ST_WB_B);
    rf_waddr_o = (state_q == ST_WB_B) ? cidx_q[1] : cidx_q[0];
    rf_wdata_o = (state_q == ST_WB_B) ? wb_data[1] : wb_data[0];
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/dcas_seq_chk.sv
module dcas_seq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              rf_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [3:0]        flags_o
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     rd_cnt <= '0;
    else if (!busy_o)                                rd_cnt <= '0;
    else if (mem_req_o && mem_ack_i && !mem_we_o && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_write_after_reads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> rd_cnt == 2'd2);

  assert_wb_no_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_req_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o && !rf_we_o);

  assert_flags_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(flags_o));
endmodule

bind dcas_seq dcas_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_chk (.*);

// File: tb/dcas_seq_bench.sv
`timescale 1ns/1ps
module dcas_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [11:0]  sel = '0;
  logic         wide = 1'b0;
  logic [15:0]  addr_a = '0, addr_b = '0;
  logic [255:0] regs_flat;
  logic         mem_req, mem_we, mem_wide, mem_ack = 1'b0;
  logic [15:0]  mem_addr;
  logic [31:0]  mem_wdata, mem_rdata = '0;
  logic         rf_we;
  logic [2:0]   rf_waddr;
  logic [31:0]  rf_wdata;
  logic         busy, done;
  logic [3:0]   flags;

  logic [31:0] regs [8];
  logic [31:0] mem  [16];
  int checks = 0, errors = 0, cycles = 0;
  int lat = 0, wait_cnt = 0;
  int acc_cnt = 0, wb_cnt = 0;
  logic        acc_we [8];
  logic [15:0] acc_addr [8];
  logic [31:0] acc_data [8];
  logic [2:0]  wb_idx [4];

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) regs_flat[i*32 +: 32] = regs[i];

  dcas_seq u_dcas_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sel_i(sel), .wide_i(wide),
    .addr_a_i(addr_a), .addr_b_i(addr_b), .regs_i(regs_flat),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .busy_o(busy), .done_o(done), .flags_o(flags)
  );

  // memory and register file models, acting at the falling edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        if (acc_cnt < 8) begin
          acc_we[acc_cnt] = mem_we; acc_addr[acc_cnt] = mem_addr; acc_data[acc_cnt] = mem_wdata;
        end
        acc_cnt++;
        if (mem_we) begin
          if (mem_wide) mem[mem_addr[3:0]] = mem_wdata;
          else mem[mem_addr[3:0]][15:0] = mem_wdata[15:0];
        end else begin
          mem_rdata = mem[mem_addr[3:0]];
        end
        mem_ack = 1'b1;
      end else wait_cnt++;
    end
    if (rf_we) begin
      regs[rf_waddr] = rf_wdata;
      if (wb_cnt < 4) wb_idx[wb_cnt] = rf_waddr;
      wb_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input logic [31:0] l, input logic [31:0] c, input bit w);
    logic [32:0] d;
    logic n, z, v, cy;
    if (w) begin
      d = {1'b0, l} - {1'b0, c};
      n = d[31]; z = (d[31:0] == 0); cy = d[32];
      v = (l[31] != c[31]) && (d[31] != l[31]);
    end else begin
      d = {17'b0, l[15:0]} - {17'b0, c[15:0]};
      n = d[15]; z = (d[15:0] == 0); cy = d[16];
      v = (l[15] != c[15]) && (d[15] != l[15]);
    end
    return {n, z, v, cy};
  endfunction

  function automatic logic [31:0] hsh(input int a, input int b);
    logic [31:0] x;
    x = 32'h9E37_79B9 * (a * 8 + b + 1);
    return x ^ (x >> 13) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic run_op(input int op, input bit w, input bit m1, input bit m2,
                        input logic [11:0] s, input logic [31:0] delta);
    logic [2:0] c1, c2, u1, u2;
    logic [31:0] r0 [8];
    logic [31:0] ma0, mb0, l1, l2, ea, eb, er, u1n, u2n;
    logic [15:0] a, b;
    logic [3:0] f1, f2, ef;
    bit swap, ok;
    int t;
    c1 = s[11:9]; c2 = s[8:6]; u1 = s[5:3]; u2 = s[2:0];
    a = 16'(op % 16); b = 16'((op + 5) % 16);
    for (int i = 0; i < 8; i++) regs[i] = hsh(op, i);
    for (int i = 0; i < 16; i++) mem[i] = hsh(op + 1000, i);
    for (int i = 0; i < 8; i++) r0[i] = regs[i];
    if (w) begin
      mem[a] = m1 ? r0[c1] : r0[c1] + delta;
      mem[b] = m2 ? r0[c2] : r0[c2] - delta;
    end else begin
      mem[a][15:0] = m1 ? r0[c1][15:0] : r0[c1][15:0] + delta[15:0];
      mem[b][15:0] = m2 ? r0[c2][15:0] : r0[c2][15:0] - delta[15:0];
      mem[a][31:16] = ~r0[c1][31:16];
      mem[b][31:16] = ~r0[c2][31:16];
    end
    ma0 = mem[a]; mb0 = mem[b];
    lat = op % 3;
    acc_cnt = 0; wb_cnt = 0;
    sel = s; wide = w; addr_a = a; addr_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sel = ~s; wide = ~w; addr_a = 16'hFFFF; addr_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    start = 1'b1;   // ignored while busy (R8)
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    check(done, "R8", "done seen", 64'(done), 64'd1);
    check(!busy, "R8", "busy low at done", 64'(busy), 64'd0);

    l1 = w ? ma0 : {16'b0, ma0[15:0]};
    l2 = w ? mb0 : {16'b0, mb0[15:0]};
    u1n = w ? r0[u1] : {16'b0, r0[u1][15:0]};
    u2n = w ? r0[u2] : {16'b0, r0[u2][15:0]};
    f1 = exp_flags(l1, r0[c1], w);
    f2 = exp_flags(l2, r0[c2], w);
    swap = f1[2] && f2[2];
    ef = f1[2] ? f2 : f1;
    check(flags == ef, "R7", "flags", 64'(flags), 64'(ef));

    check(acc_cnt == (swap ? 4 : 2), swap ? "R3" : "R4", "access count", 64'(acc_cnt), 64'(swap ? 4 : 2));
    ok = (acc_cnt >= 2) && !acc_we[0] && acc_addr[0] == a && !acc_we[1] && acc_addr[1] == b;
    check(ok, "R2", "read order", {acc_addr[0], acc_addr[1]}, {a, b});
    if (swap && acc_cnt == 4) begin
      ok = acc_we[2] && acc_addr[2] == a && acc_data[2] == u1n &&
           acc_we[3] && acc_addr[3] == b && acc_data[3] == u2n;
      check(ok, "R3", "write order and data", {acc_data[2], acc_data[3]}, {u1n, u2n});
    end
    ea = swap ? (w ? r0[u1] : {ma0[31:16], r0[u1][15:0]}) : ma0;
    eb = swap ? (w ? r0[u2] : {mb0[31:16], r0[u2][15:0]}) : mb0;
    if (a == b) ea = eb;
    check(mem[a] == ea && mem[b] == eb, swap ? "R3" : "R4", "memory contents", {mem[a], mem[b]}, {ea, eb});

    check(wb_cnt == 2 && wb_idx[0] == c1 && wb_idx[1] == c2, "R1", "write-back indices",
          {wb_idx[0], wb_idx[1]}, {c1, c2});
    for (int i = 0; i < 8; i++) begin
      er = r0[i];
      if (i == c1) er = w ? l1 : {r0[c1][31:16], l1[15:0]};
      if (i == c2) er = w ? l2 : {r0[c2][31:16], l2[15:0]};
      check(regs[i] == er, (!w && (i == c1 || i == c2)) ? "R6" : "R5", "register write-back", 64'(regs[i]), 64'(er));
    end
    @(negedge clk);
    check(!done, "R8", "done one cycle", 64'(done), 64'd0);
    @(negedge clk);
    check(!busy && acc_cnt == (swap ? 4 : 2), "R8", "no extra operation", 64'(acc_cnt), 64'(swap ? 4 : 2));
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] sels [6];
    logic [31:0] deltas [3];
    int op;
    sels[0] = {3'd0, 3'd1, 3'd2, 3'd3};
    sels[1] = {3'd4, 3'd5, 3'd6, 3'd7};
    sels[2] = {3'd2, 3'd2, 3'd3, 3'd4};
    sels[3] = {3'd1, 3'd0, 3'd1, 3'd0};
    sels[4] = {3'd7, 3'd3, 3'd3, 3'd7};
    sels[5] = {3'd5, 3'd6, 3'd0, 3'd0};
    deltas[0] = 32'h0000_0001;
    deltas[1] = 32'hFFFF_FFFF;
    deltas[2] = 32'h8000_8000;
    for (int i = 0; i < 8; i++) regs[i] = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we && flags == 4'h0, "R9", "reset outputs",
          {busy, done, mem_req, rf_we, flags}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we && flags == 4'h0, "R9", "idle after reset",
          {busy, done, mem_req, rf_we, flags}, 64'd0);
    op = 0;
    for (int w = 0; w < 2; w++)
      for (int pat = 0; pat < 4; pat++)
        for (int si = 0; si < 6; si++)
          for (int di = 0; di < 3; di++) begin
            run_op(op, w[0], pat[0], pat[1], sels[si], deltas[di]);
            op++;
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule